// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This unit watches the transactions a CPU core places on its bus and tells the core when a programmed debug condition is seen. Each of its two channels compares the transaction address under a mask, and can also qualify on operand size, bus select, instruction fetch versus operand access, read versus write and the address-space identifier (ASID). Channel 1 adds a masked data-value compare and a down-counter, so that it breaks only on the Nth qualifying access. The two channels may be chained: one must hit first, and the break is raised only when the other hits on a later cycle.

Every hit sets a sticky per-channel match flag that stays set until software writes 0 to it. When the two channels hit on the same cycle they still produce a single break request. The request is dropped while the core reports that exceptions are blocked. The flags are still set in that case. Setup is done through a simple single-cycle register write port. The core is expected to program every field first and set the channel enable bit last.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset, `brk_req` and `match_flags` are 0, and all setup registers are 0, so both channels are disabled.
- R2: Setup writes take effect on the cycle after `cfg_we`. Register index on `cfg_addr`: 0 ch0 control, 1 ch0 address, 2 ch0 address mask, 3 ch1 control, 4 ch1 address, 5 ch1 address mask, 6 ch1 data, 7 ch1 data mask, 8 ch1 count, 9 flags. Control bit 0 enables the channel. A channel whose enable bit is 0 never hits.
- R3: A channel compares `bus_addr` with its address register. Each address-mask bit that is 1 excludes that bit from the compare.
- R4: Control bits [3:1]: when bit 1 is set, `bus_size` must equal bits [3:2]. Bit 4 accepts fetches (`bus_fetch`=1) and bit 5 accepts operand accesses. Bit 6 accepts reads (`bus_write`=0) and bit 7 accepts writes. When bit 9 is set, `bus_sel` must equal bit 8.
- R5: When control bit 10 is set, `bus_asid` must equal control bits [16+IW-1:16]. When bit 10 is clear, the ASID is ignored.
- R6: When channel 1 control bit 11 is set, `bus_data` must equal the data register in every bit where the data mask is 0.
- R7: When channel 1 control bit 12 is set, a qualifying access hits only if the count register is at most 1. Otherwise the access decrements the count. The count then holds, so every later qualifying access hits, until the count is rewritten. A count write takes priority over a decrement in the same cycle.
- R8: When channel 1 control bit 13 is set, the break is sequential. Bit 14 selects which channel comes first (0: channel 0, 1: channel 1). A hit of the first channel arms the sequence. The break fires on a hit of the other channel in a later cycle while armed, and firing disarms the sequence. Without an armed sequence, a hit of the second channel raises no break.
- R9: A hit of channel n sets `match_flags[n]` on the next cycle. A write to register 9 clears each flag whose write-data bit is 0 and leaves the others unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R10: When a break fires, `brk_req` is 1 for the single cycle after the triggering access. Simultaneous hits on both channels give one request and set both flags.
- R11: A break that fires while `cpu_block` is 1 produces no request. The match flags are still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_addr | input | 4 | Setup register index |
| cfg_wdata | input | 32 | Setup write data |
| bus_valid | input | 1 | A bus transaction is present this cycle |
| bus_addr | input | AW | Transaction address |
| bus_data | input | DW | Transaction data |
| bus_asid | input | IW | Address-space identifier of the transaction |
| bus_size | input | 2 | Operand size code |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for operand access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_sel | input | 1 | Bus select of the transaction |
| cpu_block | input | 1 | Core exception-block state; 1 masks the request |
| brk_req | output | 1 | Break request pulse to the core |
| match_flags | output | 2 | Sticky match flags, bit n for channel n |

## Verification
Every result of this block is due exactly one clock edge after its cause. `brk_req` and `match_flags` reflect the transaction presented before that edge, and a setup write governs the transaction presented on the following cycle. The bench therefore drives each transaction or write at the falling edge. It predicts the outcome from its own model of the programmed state and compares at the next falling edge. Multi-cycle behaviour is checked one step at a time, with the model carrying the state between steps. This covers the count reaching its limit, arming and firing a sequence, and a flag clear racing a hit.

// File: rtl/dbg_break_unit.sv
module dbg_break_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [IW-1:0] bus_asid,
  input  logic [1:0]    bus_size,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic          bus_sel,
  input  logic          cpu_block,
  output logic          brk_req,
  output logic [1:0]    match_flags
);
  localparam int CTLW = 16 + IW;

  logic [CTLW-1:0] ctl0, ctl1;
  logic [AW-1:0]   adr0, adr1, msk0, msk1;
  logic [DW-1:0]   dat1, dmsk1;
  logic [CW-1:0]   cnt1;
  logic            armed;

  function automatic logic attr_ok(input logic [CTLW-1:0] c);
    return (!c[1] || bus_size == c[3:2]) &&
           (bus_fetch ? c[4] : c[5]) &&
           (bus_write ? c[7] : c[6]) &&
           (!c[9] || bus_sel == c[8]) &&
           (!c[10] || bus_asid == c[16 +: IW]);
  endfunction

  logic raw0, raw1, hit0, hit1, cnt_gate, first_hit, second_hit, fire;
  logic seq_en, seq_first, cnt_en, flag_wr;

  assign seq_en    = ctl1[13];
  assign seq_first = ctl1[14];
  assign cnt_en    = ctl1[12];

  assign raw0 = bus_valid && ctl0[0] && attr_ok(ctl0) &&
                (((bus_addr ^ adr0) & ~msk0) == '0);
  assign raw1 = bus_valid && ctl1[0] && attr_ok(ctl1) &&
                (((bus_addr ^ adr1) & ~msk1) == '0) &&
                (!ctl1[11] || (((bus_data ^ dat1) & ~dmsk1) == '0));

  assign cnt_gate   = !cnt_en || cnt1 <= CW'(1);
  assign hit0       = raw0;
  assign hit1       = raw1 && cnt_gate;
  assign first_hit  = seq_first ? hit1 : hit0;
  assign second_hit = seq_first ? hit0 : hit1;
  assign fire       = seq_en ? (armed && second_hit) : (hit0 || hit1);
  assign flag_wr    = cfg_we && cfg_addr == 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0; ctl1 <= '0;
      adr0 <= '0; adr1 <= '0;
      msk0 <= '0; msk1 <= '0;
      dat1 <= '0; dmsk1 <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: ctl0  <= cfg_wdata[CTLW-1:0];
        4'd1: adr0  <= cfg_wdata[AW-1:0];
        4'd2: msk0  <= cfg_wdata[AW-1:0];
        4'd3: ctl1  <= cfg_wdata[CTLW-1:0];
        4'd4: adr1  <= cfg_wdata[AW-1:0];
        4'd5: msk1  <= cfg_wdata[AW-1:0];
        4'd6: dat1  <= cfg_wdata[DW-1:0];
        4'd7: dmsk1 <= cfg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt1 <= '0;
    else if (cfg_we && cfg_addr == 4'd8)
      cnt1 <= cfg_wdata[CW-1:0];
    else if (raw1 && cnt_en && !cnt_gate)
      cnt1 <= cnt1 - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      brk_req     <= 1'b0;
      match_flags <= 2'b00;
    end else begin
      armed       <= seq_en && !fire && (armed || first_hit);
      brk_req     <= fire && !cpu_block;
      match_flags <= (flag_wr ? (match_flags & cfg_wdata[1:0]) : match_flags)
                     | {hit1, hit0};
    end
  end
endmodule

module dbg_break_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        bus_valid,
  input logic        cpu_block,
  input logic        brk_req,
  input logic [1:0]  match_flags
);
  // R11
  bl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(!cpu_block));

  // R10
  req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> match_flags != 2'b00);

  // R2
  req_needs_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid));

  // R9
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flags[0] && !(cfg_we && cfg_addr == 4'd9 && !cfg_wdata[0])) |=> match_flags[0]);

  // R9
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flags[1] && !(cfg_we && cfg_addr == 4'd9 && !cfg_wdata[1])) |=> match_flags[1]);
endmodule

bind dbg_break_unit dbg_break_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .cpu_block(cpu_block),
  .brk_req(brk_req), .match_flags(match_flags)
);

// File: tb/dbg_break_unit_bench.sv
`timescale 1ns/1ps
module dbg_break_unit_bench;
  localparam int AW = 32, DW = 32, IW = 8, CW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [3:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic bus_valid = 0; logic [AW-1:0] bus_addr = 0; logic [DW-1:0] bus_data = 0;
  logic [IW-1:0] bus_asid = 0; logic [1:0] bus_size = 0;
  logic bus_fetch = 0, bus_write = 0, bus_sel = 0, cpu_block = 0;
  logic brk_req; logic [1:0] match_flags;

  always #2.5 clk = ~clk;

  dbg_break_unit #(.AW(AW), .DW(DW), .IW(IW), .CW(CW)) u_dbg_break_unit (.*);

  int checks = 0, errors = 0;

  // bench-side model of programmed state
  logic [31:0] m_ctl0 = 0, m_ctl1 = 0, m_adr0 = 0, m_adr1 = 0, m_msk0 = 0, m_msk1 = 0;
  logic [31:0] m_dat = 0, m_dmsk = 0;
  logic [CW-1:0] m_cnt = 0;
  logic m_arm = 0; logic [1:0] m_flags = 0;

  localparam logic [31:0] EN = 1, SZC = 2, FE = 16, OP = 32, RD = 64, WRT = 128,
    BSV = 256, BSC = 512, AEN = 1024, DEN = 2048, CEN = 4096, SEQ = 8192, F1 = 16384;
  localparam logic [31:0] ANY = FE | OP | RD | WRT;

  function automatic logic m_attr(input logic [31:0] c);
    return (!c[1] || bus_size == c[3:2]) && (bus_fetch ? c[4] : c[5]) &&
           (bus_write ? c[7] : c[6]) && (!c[9] || bus_sel == c[8]) &&
           (!c[10] || bus_asid == c[23:16]);
  endfunction

  function automatic logic m_hit0();
    return bus_valid && m_ctl0[0] && m_attr(m_ctl0) && ((bus_addr & ~m_msk0) == (m_adr0 & ~m_msk0));
  endfunction

  function automatic logic m_raw1();
    return bus_valid && m_ctl1[0] && m_attr(m_ctl1) && ((bus_addr & ~m_msk1) == (m_adr1 & ~m_msk1)) &&
           (!m_ctl1[11] || ((bus_data & ~m_dmsk) == (m_dat & ~m_dmsk)));
  endfunction

  task automatic step(input string tag);
    logic h0, r1, h1, fh, sh, fire, eb; logic [1:0] ef;
    h0 = m_hit0(); r1 = m_raw1();
    h1 = r1 && (!m_ctl1[12] || m_cnt <= 1);
    fh = m_ctl1[14] ? h1 : h0; sh = m_ctl1[14] ? h0 : h1;
    fire = m_ctl1[13] ? (m_arm && sh) : (h0 || h1);
    eb = fire && !cpu_block;
    ef = ((cfg_we && cfg_addr == 9) ? (m_flags & cfg_wdata[1:0]) : m_flags) | {h1, h0};
    m_arm = m_ctl1[13] && !fire && (m_arm || fh);
    if (cfg_we && cfg_addr == 8) m_cnt = cfg_wdata[CW-1:0];
    else if (r1 && m_ctl1[12] && m_cnt > 1) m_cnt = m_cnt - 1;
    if (cfg_we) case (cfg_addr)
      0: m_ctl0 = cfg_wdata & 32'hFF_FFFF; 1: m_adr0 = cfg_wdata; 2: m_msk0 = cfg_wdata;
      3: m_ctl1 = cfg_wdata & 32'hFF_FFFF; 4: m_adr1 = cfg_wdata; 5: m_msk1 = cfg_wdata;
      6: m_dat = cfg_wdata; 7: m_dmsk = cfg_wdata; default: ;
    endcase
    m_flags = ef;
    @(posedge clk); @(negedge clk);
    checks++;
    if (brk_req !== eb || match_flags !== ef) begin
      errors++;
      $display("FAIL %s: brk_req=%b flags=%b expected brk_req=%b flags=%b", tag, brk_req, match_flags, eb, ef);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; bus_valid = 0;
    step(tag);
    cfg_we = 0;
  endtask

  task automatic txn(input logic [31:0] a, input logic [31:0] d, input logic [7:0] asid,
                     input logic [1:0] sz, input logic f, input logic w, input logic s, input string tag);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_asid = asid; bus_size = sz;
    bus_fetch = f; bus_write = w; bus_sel = s;
    step(tag);
    bus_valid = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; @(negedge clk);
    checks++;
    if (brk_req !== 0 || match_flags !== 0) begin
      errors++; $display("FAIL R1: brk_req=%b flags=%b expected 0 00", brk_req, match_flags);
    end
    txn(32'h0, 0, 0, 0, 0, 0, 0, "R1");

    // R2 enable last
    wr(1, 32'h1000, "R2"); wr(0, ANY, "R2");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R2");
    wr(0, ANY | EN, "R2");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R2");
    wr(9, 0, "R9");
    // R3 masks
    wr(2, 32'hF, "R3");
    txn(32'h100A, 0, 0, 0, 0, 1, 0, "R3");
    txn(32'h1010, 0, 0, 0, 0, 1, 0, "R3");
    wr(9, 0, "R9");
    // R4 attributes
    wr(0, ANY | EN | SZC | (1 << 2), "R4");
    txn(32'h1000, 0, 0, 2, 0, 0, 0, "R4");
    txn(32'h1000, 0, 0, 1, 0, 0, 0, "R4");
    wr(0, EN | FE | RD, "R4"); wr(9, 0, "R4");
    txn(32'h1000, 0, 0, 0, 1, 1, 0, "R4");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R4");
    txn(32'h1000, 0, 0, 0, 1, 0, 0, "R4");
    wr(0, ANY | EN | BSC | BSV, "R4"); wr(9, 0, "R4");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R4");
    txn(32'h1000, 0, 0, 0, 0, 0, 1, "R4");
    // R5 ASID
    wr(0, ANY | EN | AEN | (5 << 16), "R5"); wr(9, 0, "R5");
    txn(32'h1000, 0, 4, 0, 0, 0, 0, "R5");
    txn(32'h1000, 0, 5, 0, 0, 0, 0, "R5");
    // R6 data on channel 1
    wr(0, 0, "R6"); wr(9, 0, "R6");
    wr(4, 32'h2000, "R6"); wr(6, 32'hAB, "R6"); wr(7, 32'hF, "R6");
    wr(3, ANY | EN | DEN, "R6");
    txn(32'h2000, 32'hBB, 0, 0, 0, 1, 0, "R6");
    txn(32'h2000, 32'hA3, 0, 0, 0, 1, 0, "R6");
    // R7 count
    wr(8, 3, "R7"); wr(3, ANY | EN | CEN, "R7"); wr(9, 0, "R7");
    for (int i = 0; i < 5; i++) txn(32'h2000, 0, 0, 0, 0, 0, 0, "R7");
    wr(8, 2, "R7");
    for (int i = 0; i < 2; i++) txn(32'h2000, 0, 0, 0, 0, 0, 0, "R7");
    // R8 sequence, channel 0 first then channel 1 first
    wr(0, ANY | EN, "R8"); wr(2, 0, "R8"); wr(3, ANY | EN | SEQ, "R8"); wr(9, 0, "R8");
    txn(32'h2000, 0, 0, 0, 0, 0, 0, "R8");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R8");
    txn(32'h2000, 0, 0, 0, 0, 0, 0, "R8");
    txn(32'h2000, 0, 0, 0, 0, 0, 0, "R8");
    wr(3, ANY | EN | SEQ | F1, "R8");
    txn(32'h2000, 0, 0, 0, 0, 0, 0, "R8");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R8");
    // R10 simultaneous hits
    wr(3, ANY | EN, "R10"); wr(4, 32'h1000, "R10"); wr(9, 0, "R10");
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R10");
    // R9 selective clear, clear racing a hit
    wr(9, 32'h2, "R9");
    cfg_we = 1; cfg_addr = 9; cfg_wdata = 0;
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R9");
    cfg_we = 0;
    wr(9, 0, "R9");
    // R11 block bit
    cpu_block = 1;
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R11");
    cpu_block = 0;
    txn(32'h1000, 0, 0, 0, 0, 0, 0, "R11");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 40 == 0) begin
        wr(0, ($urandom & 32'h7FFF) | ((32'($urandom) & 3) << 16), "R2");
        wr(3, ($urandom & 32'h7FFF) | ((32'($urandom) & 3) << 16), "R8");
        wr(1, 32'h1000 | ($urandom & 3), "R3"); wr(2, $urandom & 3, "R3");
        wr(4, 32'h1000 | ($urandom & 3), "R3"); wr(5, $urandom & 3, "R3");
        wr(6, $urandom & 15, "R6"); wr(7, $urandom & 3, "R6");
        wr(8, $urandom & 7, "R7");
        if ($urandom % 2 == 0) wr(9, $urandom & 3, "R9");
      end
      cpu_block = ($urandom % 8 == 0);
      txn(32'h1000 | ($urandom & 7), $urandom & 15, 8'($urandom & 3), 2'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule